// File: doc/BRIEF.md
# MII Receive Nibble Assembler

This block is the MAC-side receive path for one port of a 10/100 media-independent interface. It samples the receive nibble bus, the data-valid line and the receive-error line on every rising edge of the recovered receive clock. All of its logic runs in that single clock domain. The receive clock runs at 25 MHz at 100 Mb/s and at 2.5 MHz at 10 Mb/s.

In byte mode the block waits for data valid and hunts for the start-of-frame delimiter, which is nibble 0x5 followed by nibble 0xD. It then packs the following nibbles into bytes, low nibble first. Each byte leaves with start and end markers, and the frame end carries two error flags. Byte output lags by one byte so that the last byte can carry the end marker on the edge where data valid is seen low.

When `slow_mode` is set (10 Mb/s operation), the inverted delimiter 0xA followed by 0x2 is reported as an error and the frame is dropped. When `sym_mode` is set, the error line becomes the fifth bit of a raw 5-bit symbol, and one symbol is passed out on every clock.

Top module: `mii_rx_assembler`

## Requirements
- R1: While `rst_n` is low, all strobes and flags (`byte_vld`, `byte_sof`, `byte_eof`, `frame_err`, `dribble_err`, `sfd_err`, `sym_vld`) are 0. A byte pending when reset is applied is never output.
- R2: In byte mode, nibbles that arrive while `rx_dv` is high are discarded until nibble 0x5 is sampled and nibble 0xD is sampled on the next edge. The first byte of the frame comes out with `byte_sof` = 1.
- R3: The first nibble of each pair after the delimiter becomes `byte_data[3:0]`, and the second becomes `byte_data[7:4]`.
- R4: A completed byte is output with `byte_vld` = 1 on the edge that completes the next byte. The last byte is output on the edge that samples `rx_dv` low, together with `byte_eof` = 1.
- R5: If `rx_dv` falls after an odd number of data nibbles, `dribble_err` = 1 comes with `byte_eof`, and the unpaired nibble is not output.
- R6: If `rx_er` is sampled high on any edge of a frame where `rx_dv` is high (preamble or data), `frame_err` = 1 comes with `byte_eof`. The flag is cleared before the next frame.
- R7: With `slow_mode` = 1, nibble 0xA followed by nibble 0x2 while searching gives a one-cycle `sfd_err` pulse. No byte or end marker is output until `rx_dv` has fallen. With `slow_mode` = 0, that pair is treated as preamble.
- R8: With `sym_mode` = 1, every edge outputs `sym_data` = {`rx_er`, `rxd`} with `sym_vld` = 1, and no byte strobe, end marker or error flag is raised. With `sym_mode` = 0, `sym_vld` = 0.
- R9: If `rx_dv` falls before a delimiter is found, nothing is output.
- R10: A frame that ends after the delimiter but before any complete byte gives `byte_eof` = 1 with `byte_vld` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_mode | input | 1 | 1 = raw 5-bit symbol pass-through |
| slow_mode | input | 1 | 1 = 10 Mb/s operation, inverted delimiter check enabled |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error, or symbol bit 4 in symbol mode |
| rxd | input | 4 | Receive nibble |
| byte_data | output | 8 | Assembled byte |
| byte_vld | output | 1 | `byte_data` valid this cycle |
| byte_sof | output | 1 | First byte of frame |
| byte_eof | output | 1 | Frame end |
| frame_err | output | 1 | Receive error seen in frame (with `byte_eof`) |
| dribble_err | output | 1 | Odd nibble count (with `byte_eof`) |
| sfd_err | output | 1 | Inverted delimiter seen (pulse) |
| sym_data | output | 5 | Raw symbol |
| sym_vld | output | 1 | `sym_data` valid this cycle |

## Verification
Every output is registered, so the response to a given sampling edge is visible right after that edge. Symbols and `sfd_err` follow the edge that sampled the triggering nibble. A byte follows the edge that completes the next byte, or the edge that sees `rx_dv` low. The bench drives inputs on the falling edge. It checks every output on the next falling edge, half a period after the rising edge that sampled them, and so each check sees the result of exactly one sampling edge.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_DATA = 2'd2,
        ST_DROP = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic vld;
        logic sof;
        logic eof;
        logic ferr;
        logic drib;
        logic sfd_bad;
    } rx_flags_t;

endpackage

// File: rtl/mii_sfd_match.sv
module mii_sfd_match #(
    parameter int               NIB_W  = 4,
    parameter logic [NIB_W-1:0] FIRST  = 4'h5,
    parameter logic [NIB_W-1:0] SECOND = 4'hD
) (
    input  logic [NIB_W-1:0] prev_nib,
    input  logic [NIB_W-1:0] cur_nib,
    output logic             hit
);
    always_comb begin
        hit = (prev_nib == FIRST) && (cur_nib == SECOND);
    end
endmodule

// File: rtl/mii_sym_stage.sv
module mii_sym_stage #(
    parameter int NIB_W = 4,
    localparam int SYM_W = NIB_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rx_er,
    input  logic [NIB_W-1:0] rxd,
    output logic [SYM_W-1:0] sym_data,
    output logic             sym_vld
);
    typedef struct packed {
        logic [SYM_W-1:0] data;
        logic             vld;
    } sym_reg_t;

    sym_reg_t sym_d, sym_q;

    always_comb begin
        sym_d     = sym_q;
        sym_d.vld = en;
        if (en) begin
            sym_d.data = {rx_er, rxd};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_q <= '0;
        end else begin
            sym_q <= sym_d;
        end
    end

    assign sym_data = sym_q.data;
    assign sym_vld  = sym_q.vld;

    AST_SYM_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |-> $past(en)) else $error("symbol strobe outside mode"); // R8
    AST_SYM_DATA_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |-> sym_data == $past({rx_er, rxd})) else $error("symbol mismatch"); // R8
endmodule

// File: rtl/mii_rx_frame.sv
module mii_rx_frame
    import mii_rx_pkg::*;
#(
    parameter int               NIB_W   = 4,
    parameter logic [NIB_W-1:0] SFD_A   = 4'h5,
    parameter logic [NIB_W-1:0] SFD_B   = 4'hD,
    localparam int              BYTE_W  = 2 * NIB_W,
    localparam logic [NIB_W-1:0] INV_A  = ~SFD_A,
    localparam logic [NIB_W-1:0] INV_B  = ~SFD_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              slow,
    input  logic              rx_dv,
    input  logic              rx_er,
    input  logic [NIB_W-1:0]  rxd,
    output logic [BYTE_W-1:0] byte_o,
    output rx_flags_t         flags_o
);
    typedef struct packed {
        rx_state_e         st;
        logic [NIB_W-1:0]  prev;
        logic [NIB_W-1:0]  lo;
        logic              half;
        logic [BYTE_W-1:0] pend;
        logic              pend_vld;
        logic              pend_sof;
        logic              got_byte;
        logic              sticky;
        logic [BYTE_W-1:0] out_byte;
        rx_flags_t         out_flags;
    } frame_reg_t;

    frame_reg_t fr_d, fr_q;
    logic       sfd_ok, sfd_inv;

    mii_sfd_match #(.NIB_W(NIB_W), .FIRST(SFD_A), .SECOND(SFD_B)) i_sfd_ok (
        .prev_nib (fr_q.prev),
        .cur_nib  (rxd),
        .hit      (sfd_ok)
    );

    mii_sfd_match #(.NIB_W(NIB_W), .FIRST(INV_A), .SECOND(INV_B)) i_sfd_inv (
        .prev_nib (fr_q.prev),
        .cur_nib  (rxd),
        .hit      (sfd_inv)
    );

    always_comb begin
        fr_d           = fr_q;
        fr_d.out_flags = '0;
        if (!en) begin
            fr_d.st       = ST_IDLE;
            fr_d.pend_vld = 1'b0;
            fr_d.half     = 1'b0;
            fr_d.sticky   = 1'b0;
        end else begin
            unique case (fr_q.st)
                ST_IDLE: begin
                    if (rx_dv) begin
                        fr_d.st       = ST_HUNT;
                        fr_d.prev     = rxd;
                        fr_d.sticky   = rx_er;
                        fr_d.half     = 1'b0;
                        fr_d.pend_vld = 1'b0;
                        fr_d.got_byte = 1'b0;
                    end
                end
                ST_HUNT: begin
                    if (!rx_dv) begin
                        fr_d.st     = ST_IDLE;
                        fr_d.sticky = 1'b0;
                    end else begin
                        fr_d.sticky = fr_q.sticky | rx_er;
                        fr_d.prev   = rxd;
                        if (sfd_ok) begin
                            fr_d.st = ST_DATA;
                        end else if (slow && sfd_inv) begin
                            fr_d.st                = ST_DROP;
                            fr_d.out_flags.sfd_bad = 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (rx_dv) begin
                        fr_d.sticky = fr_q.sticky | rx_er;
                        if (!fr_q.half) begin
                            fr_d.lo   = rxd;
                            fr_d.half = 1'b1;
                        end else begin
                            fr_d.half = 1'b0;
                            if (fr_q.pend_vld) begin
                                fr_d.out_byte      = fr_q.pend;
                                fr_d.out_flags.vld = 1'b1;
                                fr_d.out_flags.sof = fr_q.pend_sof;
                            end
                            fr_d.pend     = {rxd, fr_q.lo};
                            fr_d.pend_vld = 1'b1;
                            fr_d.pend_sof = !fr_q.got_byte;
                            fr_d.got_byte = 1'b1;
                        end
                    end else begin
                        fr_d.out_flags.eof  = 1'b1;
                        fr_d.out_flags.ferr = fr_q.sticky;
                        fr_d.out_flags.drib = fr_q.half;
                        if (fr_q.pend_vld) begin
                            fr_d.out_byte      = fr_q.pend;
                            fr_d.out_flags.vld = 1'b1;
                            fr_d.out_flags.sof = fr_q.pend_sof;
                        end
                        fr_d.st       = ST_IDLE;
                        fr_d.pend_vld = 1'b0;
                        fr_d.half     = 1'b0;
                        fr_d.sticky   = 1'b0;
                    end
                end
                ST_DROP: begin
                    if (!rx_dv) begin
                        fr_d.st     = ST_IDLE;
                        fr_d.sticky = 1'b0;
                    end
                end
                default: fr_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign byte_o  = fr_q.out_byte;
    assign flags_o = fr_q.out_flags;

    AST_EOF_ON_DV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o.eof |-> !$past(rx_dv)) else $error("end marker with dv high"); // R4
    AST_MID_BYTE_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o.vld && !flags_o.eof) |-> $past(rx_dv)) else $error("byte without dv"); // R4
    AST_DRIB_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o.drib |-> flags_o.eof) else $error("dribble flag off end"); // R5
    AST_FERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o.ferr |-> flags_o.eof) else $error("frame error off end"); // R6
    AST_SFD_BAD_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o.sfd_bad |-> ($past(slow) && !flags_o.vld && !flags_o.eof))
        else $error("bad delimiter flag misplaced"); // R7
    AST_SOF_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o.sof |-> flags_o.vld) else $error("start marker without byte"); // R2
endmodule

// File: rtl/mii_rx_assembler.sv
module mii_rx_assembler
    import mii_rx_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int BYTE_W = 2 * NIB_W,
    localparam int SYM_W  = NIB_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_mode,
    input  logic              slow_mode,
    input  logic              rx_dv,
    input  logic              rx_er,
    input  logic [NIB_W-1:0]  rxd,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_vld,
    output logic              byte_sof,
    output logic              byte_eof,
    output logic              frame_err,
    output logic              dribble_err,
    output logic              sfd_err,
    output logic [SYM_W-1:0]  sym_data,
    output logic              sym_vld
);
    rx_flags_t flags;

    mii_rx_frame #(.NIB_W(NIB_W)) i_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (!sym_mode),
        .slow    (slow_mode),
        .rx_dv   (rx_dv),
        .rx_er   (rx_er),
        .rxd     (rxd),
        .byte_o  (byte_data),
        .flags_o (flags)
    );

    mii_sym_stage #(.NIB_W(NIB_W)) i_sym (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (sym_mode),
        .rx_er    (rx_er),
        .rxd      (rxd),
        .sym_data (sym_data),
        .sym_vld  (sym_vld)
    );

    assign byte_vld    = flags.vld;
    assign byte_sof    = flags.sof;
    assign byte_eof    = flags.eof;
    assign frame_err   = flags.ferr;
    assign dribble_err = flags.drib;
    assign sfd_err     = flags.sfd_bad;

    AST_SYM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |-> !(byte_vld || byte_eof || frame_err || sfd_err))
        else $error("byte path active in symbol mode"); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !(byte_vld || byte_eof || sfd_err || sym_vld))
        else $error("strobe during reset"); // R1
endmodule

// File: tb/test_mii_rx_assembler.sv
module test_mii_rx_assembler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_mode = 1'b0;
    logic       slow_mode = 1'b0;
    logic       rx_dv = 1'b0;
    logic       rx_er = 1'b0;
    logic [3:0] rxd = 4'h0;
    logic [7:0] byte_data;
    logic       byte_vld, byte_sof, byte_eof, frame_err, dribble_err, sfd_err;
    logic [4:0] sym_data;
    logic       sym_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mii_rx_assembler i_mii_rx_assembler (
        .clk(clk), .rst_n(rst_n), .sym_mode(sym_mode), .slow_mode(slow_mode),
        .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
        .byte_data(byte_data), .byte_vld(byte_vld), .byte_sof(byte_sof),
        .byte_eof(byte_eof), .frame_err(frame_err), .dribble_err(dribble_err),
        .sfd_err(sfd_err), .sym_data(sym_data), .sym_vld(sym_vld)
    );

    // Row: {slow, dv, er, rxd[3:0], vld, sof, eof, ferr, drib, sfd_err, byte[7:0]}
    localparam int NV = 52;
    localparam logic [20:0] VEC [NV] = '{
        {3'b010, 4'h0, 6'b000000, 8'h00},
        {3'b010, 4'h5, 6'b000000, 8'h00},  // R9 hunt
        {3'b010, 4'h5, 6'b000000, 8'h00},
        {3'b010, 4'h5, 6'b000000, 8'h00},
        {3'b010, 4'hD, 6'b000000, 8'h00},  // R2 delimiter
        {3'b010, 4'h1, 6'b000000, 8'h00},
        {3'b010, 4'h2, 6'b000000, 8'h00},
        {3'b010, 4'h3, 6'b000000, 8'h00},
        {3'b010, 4'h4, 6'b110000, 8'h21},  // R3 low nibble first
        {3'b010, 4'hF, 6'b000000, 8'h00},
        {3'b010, 4'hE, 6'b100000, 8'h43},
        {3'b000, 4'h0, 6'b101000, 8'hEF},  // R4 last byte with end
        {3'b000, 4'h0, 6'b000000, 8'h00},
        {3'b010, 4'h5, 6'b000000, 8'h00},
        {3'b010, 4'hD, 6'b000000, 8'h00},
        {3'b010, 4'hA, 6'b000000, 8'h00},
        {3'b011, 4'hB, 6'b000000, 8'h00},  // R6 error in data
        {3'b010, 4'hC, 6'b000000, 8'h00},
        {3'b000, 4'h0, 6'b111110, 8'hBA},  // R5 dribble
        {3'b000, 4'h0, 6'b000000, 8'h00},
        {3'b010, 4'hA, 6'b000000, 8'h00},
        {3'b010, 4'h2, 6'b000000, 8'h00},  // R7 fast: no flag
        {3'b010, 4'h5, 6'b000000, 8'h00},
        {3'b010, 4'hD, 6'b000000, 8'h00},
        {3'b010, 4'h6, 6'b000000, 8'h00},
        {3'b010, 4'h7, 6'b000000, 8'h00},
        {3'b000, 4'h0, 6'b111000, 8'h76},
        {3'b100, 4'h0, 6'b000000, 8'h00},
        {3'b110, 4'hA, 6'b000000, 8'h00},
        {3'b110, 4'h2, 6'b000001, 8'h00},  // R7 inverted delimiter
        {3'b110, 4'h5, 6'b000000, 8'h00},
        {3'b110, 4'hD, 6'b000000, 8'h00},
        {3'b110, 4'h1, 6'b000000, 8'h00},
        {3'b110, 4'h2, 6'b000000, 8'h00},
        {3'b100, 4'h0, 6'b000000, 8'h00},
        {3'b110, 4'h5, 6'b000000, 8'h00},
        {3'b110, 4'hD, 6'b000000, 8'h00},
        {3'b110, 4'h8, 6'b000000, 8'h00},
        {3'b110, 4'h9, 6'b000000, 8'h00},
        {3'b100, 4'h0, 6'b111000, 8'h98},
        {3'b010, 4'h5, 6'b000000, 8'h00},
        {3'b011, 4'h5, 6'b000000, 8'h00},
        {3'b000, 4'h0, 6'b000000, 8'h00},  // R9 abort in hunt
        {3'b010, 4'h5, 6'b000000, 8'h00},
        {3'b010, 4'hD, 6'b000000, 8'h00},
        {3'b000, 4'h0, 6'b001000, 8'h00},  // R10 empty frame, error cleared
        {3'b000, 4'h0, 6'b000000, 8'h00},
        {3'b011, 4'h5, 6'b000000, 8'h00},  // R6 error in preamble
        {3'b010, 4'hD, 6'b000000, 8'h00},
        {3'b010, 4'h3, 6'b000000, 8'h00},
        {3'b010, 4'h4, 6'b000000, 8'h00},
        {3'b000, 4'h0, 6'b111100, 8'h43}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic sm, input logic sl, input logic dv,
                        input logic er, input logic [3:0] d);
        sym_mode  = sm;
        slow_mode = sl;
        rx_dv     = dv;
        rx_er     = er;
        rxd       = d;
        @(negedge clk);
    endtask

    function automatic logic [5:0] flags_now();
        return {byte_vld, byte_sof, byte_eof, frame_err, dribble_err, sfd_err};
    endfunction

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset strobes", {10'd0, flags_now()}, 16'h0000);
        check("R1 reset sym_vld", {15'd0, sym_vld}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            string tag;
            v = VEC[i];
            step(1'b0, v[20], v[19], v[18], v[17:14]);
            if (v[8])       tag = "R7";
            else if (v[9])  tag = "R5";
            else if (v[10]) tag = "R6";
            else if (v[11] && !v[13]) tag = "R10";
            else if (v[11]) tag = "R4";
            else if (v[12]) tag = "R2";
            else if (v[13]) tag = "R3";
            else            tag = "R9";
            check($sformatf("%s row %0d flags", tag, i), {10'd0, flags_now()}, {10'd0, v[13:8]});
            if (v[13])
                check($sformatf("%s row %0d byte", tag, i), {8'd0, byte_data}, {8'd0, v[7:0]});
            check($sformatf("R8 row %0d sym_vld", i), {15'd0, sym_vld}, 16'h0000);
        end

        // R8: symbol mode pass-through
        step(1'b1, 1'b0, 1'b0, 1'b1, 4'h9);
        check("R8 sym strobe", {15'd0, sym_vld}, 16'h0001);
        check("R8 sym data er high", {11'd0, sym_data}, 16'h0019);
        check("R8 no byte flags", {10'd0, flags_now()}, 16'h0000);
        begin
            logic [3:0] seq [6] = '{4'h5, 4'hD, 4'h1, 4'h2, 4'h3, 4'h4};
            for (int k = 0; k < 6; k++) begin
                step(1'b1, 1'b0, 1'b1, k[0], seq[k]);
                check("R8 sym stream data", {11'd0, sym_data}, {11'd0, k[0], seq[k]});
                check("R8 sym stream no bytes", {10'd0, flags_now()}, 16'h0000);
            end
        end
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
        check("R8 sym dv low", {10'd0, flags_now()}, 16'h0000);
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
        check("R8 sym off", {15'd0, sym_vld}, 16'h0000);
        check("R8 leave sym no end", {10'd0, flags_now()}, 16'h0000);

        // R1: reset drops a pending byte
        step(1'b0, 1'b0, 1'b1, 1'b0, 4'h5);
        step(1'b0, 1'b0, 1'b1, 1'b0, 4'hD);
        step(1'b0, 1'b0, 1'b1, 1'b0, 4'h1);
        step(1'b0, 1'b0, 1'b1, 1'b0, 4'h2);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-frame reset", {10'd0, flags_now()}, 16'h0000);
        rx_dv = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
        check("R1 pending byte lost", {10'd0, flags_now()}, 16'h0000);

        done = 1'b1;
        report();
    end
endmodule